// File: doc/BRIEF.md
# Static RAM Byte-Lane Select and Acknowledge Generator

This block sits on the slave side of a processor bus that uses an asynchronous strobe handshake. It is the glue between that bus and a static RAM built as two byte-wide halves. It decodes the address against a single 4 KB window and combines the address strobe with the upper and lower byte strobes. From these it forms two active-low byte-lane chip selects and an active-low write enable. The lane selects and the write enable are purely combinational, so they follow the strobes with no clock delay. Raising any strobe therefore ends the RAM access at once.

The block also returns the bus acknowledge. A small timer counts clock edges while a valid access is held. It drives the acknowledge low once a parameterized number of wait states has gone by. This lets a slow RAM whose address access time exceeds the budget be used without changing the bus master. The budget is three clock periods minus the master's address-valid delay and its data setup time. The acknowledge is gated by the live access condition, so it disappears in the same cycle as the strobes.

Top module: `sram_lane_select`

## Requirements
- R1: While `as_n` is 1, both `cs_hi_n` and `cs_lo_n` are 1, whatever the other inputs are.
- R2: The RAM window is 4 KB and aligned on a 4 KB boundary: an address hits when `addr[ADDR_W-1:12]` equals `REGION_BASE[ADDR_W-1:12]` (default window 0x003000 to 0x003FFF). On a miss, both lane selects are 1.
- R3: With `as_n` = 0, a hit, and both `uds_n` and `lds_n` at 0, both lane selects are 0 (word access).
- R4: With `as_n` = 0 and a hit, `uds_n` = 0 alone drives only `cs_hi_n` to 0, and `lds_n` = 0 alone drives only `cs_lo_n` to 0.
- R5: With `as_n` = 0 and a hit but both byte strobes at 1, no lane select is 0 and `dtack_n` stays 1.
- R6: A lane select returns to 1 in the same cycle, with no clock edge needed, as soon as its byte strobe or `as_n` goes to 1.
- R7: `we_n` is 0 exactly when `rd_wr_n` is 0 and at least one lane select is 0.
- R8: A valid access is `as_n` = 0, a hit and at least one byte strobe at 0. Once it holds, `dtack_n` is 1 until WAIT_STATES+1 rising clock edges have seen it. It is 0 from then on while the access holds.
- R9: With WAIT_STATES = 0, `dtack_n` goes to 0 after the first rising edge that sees a valid access.
- R10: `dtack_n` returns to 1 in the same cycle that the access stops being valid, including when `as_n` rises. It is 1 whenever `as_n` is 1.
- R11: After synchronous reset, with the bus idle, all four outputs are 1 and the wait count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the acknowledge timer |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address from the bus master |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper byte strobe, active low |
| lds_n | input | 1 | Lower byte strobe, active low |
| rd_wr_n | input | 1 | Transfer direction: 1 read, 0 write |
| cs_hi_n | output | 1 | Upper-byte RAM chip select, active low |
| cs_lo_n | output | 1 | Lower-byte RAM chip select, active low |
| we_n | output | 1 | RAM write enable, active low |
| dtack_n | output | 1 | Transfer acknowledge to the master, active low |

## Verification
The lane-select release and the acknowledge release can fall in the same cycle: a strobe rises after the wait count has expired. The bench provokes this by ending accesses at random hold lengths, both before and after the acknowledge has fired. Sometimes it raises only the byte strobes while `as_n` stays low, and sometimes it raises everything together. It then requires, before the next clock edge, that the selects, the write enable and `dtack_n` are all back at 1. The same stimulus runs through a second instance with zero wait states, so the first-edge acknowledge is judged against the same releases.

// File: rtl/sram_sel_pkg.sv
package sram_sel_pkg;

    // Window size is fixed at 4 KB: the low address bits ignored by the decode.
    localparam int WINDOW_SHIFT = 12;

    typedef struct packed {
        logic hi;   // upper lane selected
        logic lo;   // lower lane selected
        logic wr;   // write strobe to RAM
    } lane_req_t;

    // True when both addresses fall in the same 4 KB window.
    function automatic logic window_match(input logic [31:0] a, input logic [31:0] base);
        return a[31:WINDOW_SHIFT] == base[31:WINDOW_SHIFT];
    endfunction

    // Bits needed to count up to a wait limit (at least one bit).
    function automatic int wait_bits(input int waits);
        return $clog2(waits + 2);
    endfunction

endpackage

// File: rtl/sram_lane_decode.sv
module sram_lane_decode
    import sram_sel_pkg::*;
(
    input  logic      sel,       // strobe active and window hit
    input  logic      uds_n,
    input  logic      lds_n,
    input  logic      rd_wr_n,
    output lane_req_t req,
    output logic      access_ok
);
    always_comb begin
        req.hi    = sel & ~uds_n;
        req.lo    = sel & ~lds_n;
        req.wr    = (req.hi | req.lo) & ~rd_wr_n;
        access_ok = req.hi | req.lo;
    end
endmodule

// File: rtl/sram_ack_timer.sv
module sram_ack_timer
    import sram_sel_pkg::*;
#(
    parameter int WAIT_STATES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic access_ok,
    output logic ack
);
    localparam int CNT_W = wait_bits(WAIT_STATES);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_STATES);

    generate
        if (WAIT_STATES == 0) begin : g_nowait
            always_ff @(posedge clk) begin
                if (rst) ack <= 1'b0;
                else     ack <= access_ok;
            end
        end else begin : g_wait
            logic [CNT_W-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst || !access_ok) begin
                    cnt_q <= '0;
                    ack   <= 1'b0;
                end else if (cnt_q == LIMIT) begin
                    ack   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sram_lane_select.sv
module sram_lane_select
    import sram_sel_pkg::*;
#(
    parameter int          ADDR_W      = 24,
    parameter logic [31:0] REGION_BASE = 32'h0000_3000,
    parameter int          WAIT_STATES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              as_n,
    input  logic              uds_n,
    input  logic              lds_n,
    input  logic              rd_wr_n,
    output logic              cs_hi_n,
    output logic              cs_lo_n,
    output logic              we_n,
    output logic              dtack_n
);
    lane_req_t req;
    logic      hit, sel, access_ok, ack;

    assign hit = window_match(32'(addr), REGION_BASE);
    assign sel = hit & ~as_n;

    sram_lane_decode u_dec (
        .sel       (sel),
        .uds_n     (uds_n),
        .lds_n     (lds_n),
        .rd_wr_n   (rd_wr_n),
        .req       (req),
        .access_ok (access_ok)
    );

    sram_ack_timer #(.WAIT_STATES(WAIT_STATES)) u_ack (
        .clk       (clk),
        .rst       (rst),
        .access_ok (access_ok),
        .ack       (ack)
    );

    assign cs_hi_n = ~req.hi;
    assign cs_lo_n = ~req.lo;
    assign we_n    = ~req.wr;
    // Gate with the live access so the acknowledge drops with the strobes.
    assign dtack_n = ~(ack & access_ok);
endmodule

// File: rtl/sram_lane_select_chk.sv
module sram_lane_select_chk #(
    parameter int          ADDR_W      = 24,
    parameter logic [31:0] REGION_BASE = 32'h0000_3000,
    parameter int          WAIT_STATES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              as_n,
    input logic              uds_n,
    input logic              lds_n,
    input logic              rd_wr_n,
    input logic              cs_hi_n,
    input logic              cs_lo_n,
    input logic              we_n,
    input logic              dtack_n
);
    localparam int CW = $clog2(WAIT_STATES + 2);
    localparam logic [CW-1:0] SAT = CW'(WAIT_STATES + 1);

    logic          in_win, live;
    logic [CW-1:0] seen_q;

    assign in_win = (32'(addr) >> 12) == (REGION_BASE >> 12);
    assign live   = !as_n && in_win && (!uds_n || !lds_n);

    always_ff @(posedge clk) begin
        if (rst || !live)    seen_q <= '0;
        else if (seen_q != SAT) seen_q <= seen_q + 1'b1;
    end

    // R1
    as_idle_cs_chk: assert property (@(posedge clk) disable iff (rst)
        as_n |-> (cs_hi_n && cs_lo_n));
    // R2
    miss_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !in_win |-> (cs_hi_n && cs_lo_n));
    // R7
    we_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (!rd_wr_n && !(cs_hi_n && cs_lo_n)));
    // R10
    dtack_idle_chk: assert property (@(posedge clk) disable iff (rst)
        as_n |-> dtack_n);
    // R8
    dtack_due_chk: assert property (@(posedge clk) disable iff (rst)
        (live && seen_q == SAT) |-> !dtack_n);
    // R8
    dtack_early_chk: assert property (@(posedge clk) disable iff (rst)
        !dtack_n |-> (live && seen_q == SAT));
endmodule

bind sram_lane_select sram_lane_select_chk #(
    .ADDR_W(ADDR_W), .REGION_BASE(REGION_BASE), .WAIT_STATES(WAIT_STATES)
) chk_i (.*);

// File: tb/sram_lane_select_tb.sv
module sram_lane_select_tb_top;
    localparam int ADDR_W = 24;
    localparam int WS     = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rd_wr_n = 1'b1;
    logic cs_hi_n, cs_lo_n, we_n, dtack_n;
    logic z_cs_hi_n, z_cs_lo_n, z_we_n, z_dtack_n;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sram_lane_select #(.ADDR_W(ADDR_W), .REGION_BASE(32'h3000), .WAIT_STATES(WS)) dut_i (
        .clk, .rst, .addr, .as_n, .uds_n, .lds_n, .rd_wr_n,
        .cs_hi_n, .cs_lo_n, .we_n, .dtack_n);

    sram_lane_select #(.ADDR_W(ADDR_W), .REGION_BASE(32'h3000), .WAIT_STATES(0)) dut_z (
        .clk, .rst, .addr, .as_n, .uds_n, .lds_n, .rd_wr_n,
        .cs_hi_n(z_cs_hi_n), .cs_lo_n(z_cs_lo_n), .we_n(z_we_n), .dtack_n(z_dtack_n));

    function automatic bit f_hit(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:12] == 12'h003;
    endfunction
    function automatic bit f_valid();
        return !as_n && f_hit(addr) && (!uds_n || !lds_n);
    endfunction
    function automatic logic f_cs_hi();
        return !(!as_n && f_hit(addr) && !uds_n);
    endfunction
    function automatic logic f_cs_lo();
        return !(!as_n && f_hit(addr) && !lds_n);
    endfunction
    function automatic logic f_we();
        return !(!rd_wr_n && (!f_cs_hi() || !f_cs_lo()));
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b (addr=%h as=%b u=%b l=%b rw=%b)",
                     req, act, exp, addr, as_n, uds_n, lds_n, rd_wr_n);
        end
    endtask

    // Lane selects and write enable for both instances (R1..R5, R7).
    task automatic chk_lanes(input string req);
        chk({req, " cs_hi"}, cs_hi_n, f_cs_hi());
        chk({req, " cs_lo"}, cs_lo_n, f_cs_lo());
        chk("R7 we",         we_n,    f_we());
        chk({req, " z cs_hi"}, z_cs_hi_n, f_cs_hi());
        chk({req, " z cs_lo"}, z_cs_lo_n, f_cs_lo());
        chk("R7 z we",         z_we_n,    f_we());
    endtask

    // One bus access: drive at a falling edge, watch hold edges, then release.
    task automatic access(input logic [ADDR_W-1:0] a, input logic u, input logic l,
                          input logic rw, input int hold, input bit strobes_first);
        @(negedge clk);
        addr = a; rd_wr_n = rw; as_n = 1'b0; uds_n = u; lds_n = l;
        #1;
        chk_lanes(f_hit(a) ? "R3/R4/R5" : "R2");
        chk("R8 before edge", dtack_n, 1'b1);
        chk("R9 before edge", z_dtack_n, 1'b1);
        for (int k = 1; k <= hold; k++) begin
            @(negedge clk); #1;
            chk("R8 dtack", dtack_n, !(f_valid() && k >= WS + 1));
            chk("R9 dtack", z_dtack_n, !(f_valid() && k >= 1));
            if (!f_valid()) chk("R5 no dtack", dtack_n, 1'b1);
        end
        #1;
        if (strobes_first) begin
            uds_n = 1'b1; lds_n = 1'b1;
            #1;
            chk_lanes("R6");
            chk("R10 strobe release", dtack_n, 1'b1);
            chk("R10 z strobe release", z_dtack_n, 1'b1);
            #1;
        end
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
        #1;
        chk_lanes("R1/R6");
        chk("R10 as release", dtack_n, 1'b1);
        chk("R10 z as release", z_dtack_n, 1'b1);
        @(posedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'h5EED);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R11 reset state
        chk("R11 cs_hi", cs_hi_n, 1'b1);
        chk("R11 cs_lo", cs_lo_n, 1'b1);
        chk("R11 we", we_n, 1'b1);
        chk("R11 dtack", dtack_n, 1'b1);

        // R1: strobes low but AS high
        @(negedge clk); addr = 24'h003100; uds_n = 1'b0; lds_n = 1'b0; rd_wr_n = 1'b0; #1;
        chk_lanes("R1");
        chk("R1 dtack", dtack_n, 1'b1);
        @(negedge clk); #1;
        chk("R10 as high", dtack_n, 1'b1);
        uds_n = 1'b1; lds_n = 1'b1; rd_wr_n = 1'b1;

        // Directed window edges and lane patterns
        access(24'h002FFF, 1'b0, 1'b0, 1'b1, 4, 1'b0); // R2 below
        access(24'h003000, 1'b0, 1'b0, 1'b1, 4, 1'b0); // R3 word read
        access(24'h003FFF, 1'b0, 1'b1, 1'b0, 4, 1'b1); // R4 upper write
        access(24'h003800, 1'b1, 1'b0, 1'b0, 5, 1'b0); // R4 lower write
        access(24'h004000, 1'b0, 1'b0, 1'b0, 4, 1'b0); // R2 above
        access(24'h003200, 1'b1, 1'b1, 1'b0, 4, 1'b0); // R5 no strobes
        access(24'h003010, 1'b0, 1'b0, 1'b1, 0, 1'b0); // R6 release before edge
        access(24'h003010, 1'b0, 1'b0, 1'b0, WS + 1, 1'b1); // R8 exact edge

        // Reset mid-access: R11 wait count restarts
        @(negedge clk); addr = 24'h003004; as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b1; @(negedge clk); rst = 1'b0; #1;
        chk("R11 dtack after reset", dtack_n, 1'b1);
        for (int k = 1; k <= WS + 1; k++) begin
            @(negedge clk); #1;
            chk("R11 recount", dtack_n, !(k >= WS + 1));
        end
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
        @(posedge clk);

        // Constrained random accesses
        for (int n = 0; n < 150; n++) begin
            logic [ADDR_W-1:0] a;
            if ($urandom_range(3) != 0) a = {12'h003, 12'($urandom)};
            else                        a = ADDR_W'($urandom);
            access(a, 1'($urandom), 1'($urandom), 1'($urandom),
                   int'($urandom_range(6)), bit'($urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule